// File: doc/BRIEF.md
# Sync Word Correlator with Bit-Error Tolerance

This block watches a received serial bit stream for a programmed synchronisation pattern. Each accepted bit moves into a 32-bit shift window. The newest 8, 16, 24 or 32 bits of that window are compared against the upper bytes of the configured pattern. The number of differing bits is counted. When that count is no greater than the programmed tolerance, the block emits a single-cycle `sync_found` pulse. That pulse feeds the interrupt logic and tells the payload handler to begin capture. Traffic that never matches produces no event of any kind.

After a match, the correlator holds in a locked state and stops searching. It then counts the payload bits that follow, so the downstream handler knows where each byte begins and ends. When the handler raises `pkt_done`, the correlator returns to searching and must collect a full pattern length of new bits before it can match again. Dropping `enable` stops all activity, and raising it again starts a fresh search.

The controller has three named states:
- **ST_IDLE**: the correlator is disabled.
- **ST_SEARCH**: the correlator is hunting for the pattern.
- **ST_LOCKED**: a payload is being captured.

The transitions are:
- **go_search**: ST_IDLE to ST_SEARCH, taken when `enable` is high.
- **go_lock**: ST_SEARCH to ST_LOCKED, taken on a match.
- **go_rearm**: ST_LOCKED to ST_SEARCH, taken on `pkt_done`.
- **go_idle**: ST_SEARCH or ST_LOCKED to ST_IDLE, taken when `enable` is low.

Top module: `sync_correlator`

## Requirements
- R1: After reset, `sync_found`, `locked`, `byte_strobe` and `bit_index` are all zero.
- R2: `size_sel` values 0, 1, 2 and 3 select pattern lengths of 8, 16, 24 and 32 bits. For a length of N bits, the compared pattern is `sync_value[31:32-N]`, sent most significant bit first. With zero mismatches, the final pattern bit produces a match.
- R3: A candidate matches only when the number of differing bits is less than or equal to `err_tol` (0 to 3). A candidate with more differing bits produces no pulse.
- R4: `sync_found` is high for exactly one cycle: the cycle after the clock edge that accepted the last pattern bit. `locked` rises in that same cycle.
- R5: No match is reported until at least N valid bits have been accepted since the search began.
- R6: While `locked` is high, no further `sync_found` is issued, whatever bits arrive. A `pkt_done` pulse returns the block to searching, and `locked` is low in the next cycle.
- R7: While locked, `bit_index` equals the number of payload bits accepted so far, modulo 8. `byte_strobe` pulses for one cycle after every eighth payload bit.
- R8: When `enable` is low, `locked` is low in the next cycle and bits produce no match. A search that resumes after `enable` returns discards any bits accepted before the pause.
- R9: Cycles where `bit_valid` is low leave the search unchanged, whatever value `bit_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Correlator enable |
| bit_in | input | 1 | Received data bit |
| bit_valid | input | 1 | Qualifies `bit_in` for one cycle |
| sync_value | input | 32 | Pattern, first transmitted bit at bit 31 |
| size_sel | input | 2 | Pattern length: (value+1)*8 bits |
| err_tol | input | 2 | Allowed mismatched bits |
| pkt_done | input | 1 | End of payload from the downstream handler |
| sync_found | output | 1 | One-cycle match pulse |
| locked | output | 1 | High while the payload is being captured |
| byte_strobe | output | 1 | Pulse after each complete payload byte |
| bit_index | output | 3 | Bit position within the current payload byte |

## Verification
A corrupted fill counter or shift window shows up at the ports as a pulse that comes one or more bits early or late, or as a pulse that never arrives. Each case feeds exactly N bits into a fresh search, so such a fault is visible on the very bit where the pulse should or should not occur. An error in the mismatch count appears as the match/no-match decision flipping at the tolerance boundary; the sweep covers every length and tolerance with zero to four flipped bits. A stuck or mis-stepping state register shows up within one bit as a wrong `locked` level, a second pulse during payload, or a `bit_index` that drifts from the payload bit count.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LOCKED = 2'd2
    } corr_state_t;
endpackage

// File: rtl/sc_shift_window.sv
// Serial-to-parallel window; cand is the window as it will be after the current bit.
module sc_shift_window #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] cand
);
    logic [W-1:0] win_q;

    assign cand = {win_q[W-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (shift_en) begin
            win_q <= cand;
        end
    end
endmodule

// File: rtl/sc_mismatch_count.sv
// Counts differing bits between the newest (size_sel+1) bytes of cand and
// the top (size_sel+1) bytes of the pattern.
module sc_mismatch_count #(
    parameter int LANES = 4,
    localparam int W    = 8 * LANES,
    localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic [W-1:0]    cand,
    input  logic [W-1:0]    pattern,
    input  logic [SELW-1:0] size_sel,
    output logic [CW-1:0]   mism
);
    logic [LANES*4-1:0] lane_cnts;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] diff;
        always_comb begin
            int ref_idx;
            ref_idx = 0;
            diff    = '0;
            if (b <= int'(size_sel)) begin
                ref_idx = (LANES - 1) - int'(size_sel) + b;
                diff    = cand[b*8 +: 8] ^ pattern[ref_idx*8 +: 8];
            end
        end
        assign lane_cnts[b*4 +: 4] = 4'($countones(diff));
    end

    always_comb begin
        mism = '0;
        for (int i = 0; i < LANES; i++) begin
            mism = mism + CW'(lane_cnts[i*4 +: 4]);
        end
    end
endmodule

// File: rtl/sc_byte_track.sv
// Payload bit position tracker used after a lock.
module sc_byte_track #(
    parameter int BYTE_BITS = 8,
    localparam int IW = $clog2(BYTE_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          bit_valid,
    output logic [IW-1:0] bit_index,
    output logic          byte_strobe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_index   <= '0;
            byte_strobe <= 1'b0;
        end else if (!active) begin
            bit_index   <= '0;
            byte_strobe <= 1'b0;
        end else if (bit_valid) begin
            bit_index   <= (bit_index == IW'(BYTE_BITS - 1)) ? '0 : bit_index + 1'b1;
            byte_strobe <= (bit_index == IW'(BYTE_BITS - 1));
        end else begin
            byte_strobe <= 1'b0;
        end
    end

    assert_strobe_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_strobe |-> (bit_index == '0));
    assert_strobe_on_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_strobe |-> $past(bit_valid));
endmodule

// File: rtl/sync_correlator.sv
module sync_correlator
    import sync_corr_pkg::*;
#(
    parameter int SYNC_BYTES = 4,
    parameter int TOL_W      = 2,
    localparam int W    = 8 * SYNC_BYTES,
    localparam int SELW = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bit_in,
    input  logic             bit_valid,
    input  logic [W-1:0]     sync_value,
    input  logic [SELW-1:0]  size_sel,
    input  logic [TOL_W-1:0] err_tol,
    input  logic             pkt_done,
    output logic             sync_found,
    output logic             locked,
    output logic             byte_strobe,
    output logic [2:0]       bit_index
);
    corr_state_t  state_q, state_d;
    logic [W-1:0] cand;
    logic [CW-1:0] mism;
    logic [CW-1:0] fill_q;
    logic [CW-1:0] need_bits;
    logic          enough_bits;
    logic          hit;
    logic          payload_active;

    sc_shift_window #(.W(W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_valid),
        .bit_in   (bit_in),
        .cand     (cand)
    );

    sc_mismatch_count #(.LANES(SYNC_BYTES)) u_mismatch (
        .cand     (cand),
        .pattern  (sync_value),
        .size_sel (size_sel),
        .mism     (mism)
    );

    assign need_bits   = CW'((int'(size_sel) + 1) * 8);
    assign enough_bits = (fill_q + CW'(1)) >= need_bits;
    assign hit = (state_q == ST_SEARCH) && enable && bit_valid && enough_bits
               && (mism <= CW'(err_tol));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (enable) state_d = ST_SEARCH;              // go_search
            ST_SEARCH: if (!enable) state_d = ST_IDLE;               // go_idle
                       else if (hit) state_d = ST_LOCKED;            // go_lock
            ST_LOCKED: if (!enable) state_d = ST_IDLE;               // go_idle
                       else if (pkt_done) state_d = ST_SEARCH;       // go_rearm
            default:   state_d = ST_IDLE;
        endcase
    end

    // output and search bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_found <= 1'b0;
            fill_q     <= '0;
        end else begin
            sync_found <= hit;
            if (state_q != ST_SEARCH || !enable) begin
                fill_q <= '0;
            end else if (bit_valid && fill_q != CW'(W)) begin
                fill_q <= fill_q + CW'(1);
            end
        end
    end

    assign locked         = (state_q == ST_LOCKED);
    assign payload_active = locked && enable && !pkt_done;

    sc_byte_track #(.BYTE_BITS(8)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (payload_active),
        .bit_valid   (bit_valid),
        .bit_index   (bit_index),
        .byte_strobe (byte_strobe)
    );

    assert_found_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |=> !sync_found);
    assert_found_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |-> locked);
    assert_found_on_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |-> $past(bit_valid));
    assert_quiet_when_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> !sync_found);
    assert_disable_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !locked);
    assert_mism_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mism <= need_bits);
endmodule

// File: tb/tb_sync_correlator.sv
module tb_sync_correlator;
    localparam logic [31:0] SYNC = 32'hA5C3_96E1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic [31:0] sync_value = SYNC;
    logic [1:0] size_sel = 2'd0;
    logic [1:0] err_tol = 2'd0;
    logic       pkt_done = 1'b0;
    logic       sync_found, locked, byte_strobe;
    logic [2:0] bit_index;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sync_correlator dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_in(bit_in),
        .bit_valid(bit_valid), .sync_value(sync_value), .size_sel(size_sel),
        .err_tol(err_tol), .pkt_done(pkt_done), .sync_found(sync_found),
        .locked(locked), .byte_strobe(byte_strobe), .bit_index(bit_index)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic b);
        bit_valid = v;
        bit_in    = b;
        @(posedge clk);
        #2;
    endtask

    task automatic restart();
        pkt_done = 1'b0;
        enable = 1'b0;
        step(1'b0, 1'b0);
        enable = 1'b1;
        step(1'b0, 1'b0);
    endtask

    // send bits [first, last] of the top-aligned pattern; returns pulse seen
    task automatic send_range(input int first, input int last, output bit seen);
        seen = 1'b0;
        for (int i = first; i <= last; i++) begin
            step(1'b1, SYNC[31-i]);
            if (sync_found) seen = 1'b1;
        end
    endtask

    function automatic bit flipped(input int i, input int k, input int n);
        for (int j = 0; j < k; j++) if ((j * 7) % n == i) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        bit seen;
        int p;
        #20;
        check("R1 sync_found", sync_found, 0);
        check("R1 locked", locked, 0);
        check("R1 byte_strobe", byte_strobe, 0);
        check("R1 bit_index", bit_index, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3/R4/R5 sweep: every size, tolerance, and 0..4 flipped bits
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 4; t++) begin
                for (int k = 0; k <= 4; k++) begin
                    int n;
                    bit early, last_found, last_lock;
                    size_sel = 2'(s);
                    err_tol  = 2'(t);
                    restart();
                    n = 8 * (s + 1);
                    early = 1'b0;
                    last_found = 1'b0;
                    last_lock = 1'b0;
                    for (int i = 0; i < n; i++) begin
                        step(1'b1, SYNC[31-i] ^ flipped(i, k, n));
                        if (i < n - 1 && sync_found) early = 1'b1;
                        last_found = sync_found;
                        last_lock  = locked;
                    end
                    if (k == 0) check("R2 exact match", last_found, 1);
                    else        check("R3 tolerance", last_found, (k <= t) ? 1 : 0);
                    if (k == 0) check("R5 no early match", early, 0);
                    if (k == 0) check("R4 locked with pulse", last_lock, 1);
                    if (k == 0) begin
                        step(1'b0, 1'b0);
                        check("R4 single cycle pulse", sync_found, 0);
                    end
                end
            end
        end

        // R9: idle cycles with garbage between valid bits
        size_sel = 2'd1;
        err_tol  = 2'd0;
        restart();
        seen = 1'b0;
        for (int i = 0; i < 16; i++) begin
            step(1'b0, ~SYNC[31-i]);
            if (sync_found) seen = 1'b1;
            step(1'b1, SYNC[31-i]);
            if (i < 15 && sync_found) seen = 1'b1;
        end
        check("R9 match at final bit", sync_found, 1);
        check("R9 no pulse from invalid cycles", seen, 0);

        // R7: payload byte tracking with gaps
        p = 0;
        for (int c = 0; c < 30; c++) begin
            bit v;
            v = (c % 3) != 2;
            step(v, c[0]);
            if (v) p++;
            check("R7 bit_index", bit_index, p % 8);
            check("R7 byte_strobe", byte_strobe, (v && (p % 8 == 0)) ? 1 : 0);
        end

        // R6: pattern during payload is ignored; pkt_done rearms
        send_range(0, 15, seen);
        check("R6 no pulse while locked", seen, 0);
        check("R6 stays locked", locked, 1);
        pkt_done = 1'b1;
        step(1'b0, 1'b0);
        pkt_done = 1'b0;
        check("R6 pkt_done unlocks", locked, 0);
        send_range(0, 15, seen);
        check("R6 rearmed match", sync_found, 1);

        // R8: enable low
        enable = 1'b0;
        step(1'b0, 1'b0);
        check("R8 disable drops lock", locked, 0);
        send_range(0, 15, seen);
        check("R8 no match when disabled", seen, 0);
        enable = 1'b1;
        step(1'b0, 1'b0);
        send_range(0, 7, seen);
        enable = 1'b0;
        step(1'b0, 1'b0);
        enable = 1'b1;
        step(1'b0, 1'b0);
        send_range(8, 15, seen);
        check("R8 search restarts after pause", seen, 0);
        send_range(0, 15, seen);
        check("R8 fresh match", sync_found, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule